// File: doc/BRIEF.md
# Sync-Triggered I/Q Power Meter

This block measures the power of one complex sample stream. Over a measurement window it sums the magnitude squared (I² + Q²) of every counted sample, keeps the largest magnitude squared seen, and runs two histogram counters. Each counter tallies the samples whose magnitude squared is above its own threshold. The window is placed by a schedule. A sync pulse restarts the sample position count. The window opens a programmed number of samples later and lasts a programmed number of samples. It then either stops until the next sync (one-shot) or repeats with a fixed period counted in samples. A gated mode uses the same schedule but counts only samples that arrive with the gate input high.

All four results are latched together when a window closes. A host collects them in one of two ways. In interrupt mode every closed window overwrites the results and raises a level interrupt, which stays high until a done-reading pulse. In handshake mode the host raises a read request. The block lets the window in progress finish, latches that window, raises an acknowledge, and then freezes the results until the request is dropped.

Top module: `iq_pwr_meter`

## Requirements
- R1: The sample in the cycle that carries `sync_evt` is not counted. Valid samples after it are numbered 0, 1, 2 and so on, and the window covers positions `cfg_delay` through `cfg_delay + cfg_length - 1`.
- R2: When a window closes, `res_power` holds the sum of I² + Q² over the window and `res_peak` holds the largest I² + Q² in it. Both appear on the clock edge that consumes the last window sample.
- R3: The power sum is `2*SW + CW` bits wide. A full window of samples at I = Q = -2^(SW-1) therefore gives the exact sum with no wrap.
- R4: With `cfg_one_shot` = 1, exactly one window closes after each sync, however many samples follow.
- R5: With `cfg_one_shot` = 0, the position wraps to 0 after position `cfg_interval - 1`, so a window opens every `cfg_interval` samples.
- R6: If `cfg_interval < cfg_delay + cfg_length`, no window ever closes and no result is raised. If `cfg_interval == cfg_delay + cfg_length`, windows do close.
- R7: `cfg_mode` 0 (and code 3) turns the meter off. Sync is ignored, no window runs, and the results do not change.
- R8: `cfg_mode` 2 runs the schedule of mode 1, but the sum, peak and histograms take only samples that arrive with `smp_gate` = 1.
- R9: `res_hist_a` and `res_hist_b` count the window samples whose I² + Q² is strictly greater than `cfg_thr_a` and `cfg_thr_b` respectively.
- R10: In interrupt mode (`cfg_handshake` = 0), each closed window overwrites the results and sets `res_irq`. `res_irq` stays high until a `rd_done` pulse clears it. A window closing in the same cycle as `rd_done` wins.
- R11: In handshake mode (`cfg_handshake` = 1), results load only when a window closes while `rd_req` = 1 and `rd_ack` = 0. That load sets `rd_ack`. The results then stay frozen until `rd_req` falls, and `rd_ack` clears one cycle later. `res_irq` stays 0 in this mode.
- R12: A sync that arrives during a running window discards that window and restarts the count at position 0.
- R13: After reset all results, `res_irq` and `rd_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 off, 1 scheduled, 2 gated, 3 off |
| cfg_one_shot | input | 1 | 1: one window per sync; 0: periodic |
| cfg_handshake | input | 1 | 0: interrupt hand-off; 1: request/acknowledge |
| cfg_delay | input | CW | Samples from sync to window start |
| cfg_length | input | CW | Window length in samples |
| cfg_interval | input | CW | Repeat period in samples |
| cfg_thr_a | input | 2*SW | Threshold of histogram A |
| cfg_thr_b | input | 2*SW | Threshold of histogram B |
| sync_evt | input | 1 | Schedule restart pulse |
| smp_valid | input | 1 | Sample strobe |
| smp_i | input | SW | In-phase sample, signed |
| smp_q | input | SW | Quadrature sample, signed |
| smp_gate | input | 1 | Sample qualifier for gated mode |
| rd_req | input | 1 | Read request (handshake mode) |
| rd_done | input | 1 | Interrupt clear (interrupt mode) |
| res_power | output | 2*SW+CW | Latched power sum |
| res_peak | output | 2*SW | Latched peak magnitude squared |
| res_hist_a | output | CW | Latched histogram A count |
| res_hist_b | output | CW | Latched histogram B count |
| res_irq | output | 1 | Result-ready interrupt, level |
| rd_ack | output | 1 | Read acknowledge (handshake mode) |

## Verification
The assertions check several properties on every cycle. The running sum never decreases inside a window. The latched peak never exceeds the latched sum. An interrupt only rises after a window closes. The acknowledge only rises under a request, and the results stay frozen while it is high. The interrupt stays low in handshake mode, and no window runs after the meter is switched off. Other behaviour needs the bench's scenarios, because it depends on whole sample sequences: the exact window placement after sync, the one-shot count, the periodic spacing, the interval boundary at which windows stop closing, gating, the histogram threshold counts, the full-scale sum, and which window a mid-stream request captures.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_OFF   = 2'd0,
    PM_SCHED = 2'd1,
    PM_GATED = 2'd2,
    PM_RSVD  = 2'd3
  } pm_mode_e;

  localparam int PM_NHIST = 2;
endpackage

// File: rtl/pm_sched.sv
// Window scheduler: sample position since sync, window placement, repeat.
module pm_sched
  import pm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          one_shot,
  input  logic [CW-1:0] dly,
  input  logic [CW-1:0] len,
  input  logic [CW-1:0] ivl,
  input  logic          sync,
  input  logic          vld,
  input  logic          gate,
  output logic          win_on,
  output logic          win_start,
  output logic          win_end,
  output logic          win_use
);
  localparam int PW = CW + 1;

  logic          active;
  logic [PW-1:0] pos;
  logic [PW-1:0] dly_x, end_x, ivl_last;
  logic          en, gated, step, in_win, last;

  always_comb begin
    en       = (mode == PM_SCHED) || (mode == PM_GATED);
    gated    = (mode == PM_GATED);
    dly_x    = {1'b0, dly};
    end_x    = {1'b0, dly} + {1'b0, len};
    ivl_last = {1'b0, ivl} - PW'(1);
    step     = en && active && vld && !sync;
    in_win   = (pos >= dly_x) && (pos < end_x);
    last     = (pos + PW'(1)) == end_x;
    win_on    = step && in_win;
    win_start = win_on && (pos == dly_x);
    win_end   = win_on && last;
    win_use   = win_on && (!gated || gate);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (sync) begin
      active <= 1'b1;
      pos    <= '0;
    end else if (step) begin
      if (one_shot) begin
        if (win_end) active <= 1'b0;
        pos <= pos + PW'(1);
      end else if (pos == ivl_last) begin
        pos <= '0;
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end
endmodule

// File: rtl/pm_accum.sv
// Window accumulators: power sum, peak and threshold histograms.
module pm_accum
  import pm_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic signed [SW-1:0]              smp_i,
  input  logic signed [SW-1:0]              smp_q,
  input  logic [PM_NHIST-1:0][2*SW-1:0]     thr,
  input  logic                              win_on,
  input  logic                              win_start,
  input  logic                              win_use,
  output logic [2*SW+CW-1:0]                acc_q,
  output logic [2*SW+CW-1:0]                nx_pwr,
  output logic [2*SW-1:0]                   nx_peak,
  output logic [PM_NHIST-1:0][CW-1:0]       nx_hist
);
  localparam int MW = 2 * SW;
  localparam int AW = MW + CW;

  logic signed [MW-1:0] sq_i, sq_q;
  logic [MW-1:0]        mag2;
  logic [MW-1:0]        peak_q, base_peak;
  logic [AW-1:0]        base_pwr;

  assign sq_i = smp_i * smp_i;
  assign sq_q = smp_q * smp_q;
  assign mag2 = $unsigned(sq_i) + $unsigned(sq_q);

  always_comb begin
    base_pwr  = win_start ? '0 : acc_q;
    base_peak = win_start ? '0 : peak_q;
    nx_pwr    = base_pwr + (win_use ? AW'(mag2) : '0);
    nx_peak   = (win_use && (mag2 > base_peak)) ? mag2 : base_peak;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      peak_q <= '0;
    end else if (win_on) begin
      acc_q  <= nx_pwr;
      peak_q <= nx_peak;
    end
  end

  for (genvar g = 0; g < PM_NHIST; g++) begin : g_hist
    logic [CW-1:0] cnt_q;
    logic          hit;
    assign hit        = win_use && (mag2 > thr[g]);
    assign nx_hist[g] = (win_start ? '0 : cnt_q) + CW'(hit);
    always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (win_on) cnt_q <= nx_hist[g];
    end
  end
endmodule

// File: rtl/pm_handoff.sv
// Result latch with interrupt or request/acknowledge hand-off.
module pm_handoff
  import pm_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         hs_mode,
  input  logic                         rd_req,
  input  logic                         rd_done,
  input  logic                         win_end,
  input  logic [2*SW+CW-1:0]           nx_pwr,
  input  logic [2*SW-1:0]              nx_peak,
  input  logic [PM_NHIST-1:0][CW-1:0]  nx_hist,
  output logic [2*SW+CW-1:0]           res_pwr,
  output logic [2*SW-1:0]              res_peak,
  output logic [PM_NHIST-1:0][CW-1:0]  res_hist,
  output logic                         irq,
  output logic                         ack
);
  logic cap;

  assign cap = win_end && (!hs_mode || (rd_req && !ack));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_pwr  <= '0;
      res_peak <= '0;
      res_hist <= '0;
      irq      <= 1'b0;
      ack      <= 1'b0;
    end else begin
      if (cap) begin
        res_pwr  <= nx_pwr;
        res_peak <= nx_peak;
        res_hist <= nx_hist;
      end
      if (hs_mode)      irq <= 1'b0;
      else if (win_end) irq <= 1'b1;
      else if (rd_done) irq <= 1'b0;
      if (!hs_mode)     ack <= 1'b0;
      else if (cap)     ack <= 1'b1;
      else if (!rd_req) ack <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_pwr_meter.sv
module iq_pwr_meter
  import pm_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             cfg_mode,
  input  logic                   cfg_one_shot,
  input  logic                   cfg_handshake,
  input  logic [CW-1:0]          cfg_delay,
  input  logic [CW-1:0]          cfg_length,
  input  logic [CW-1:0]          cfg_interval,
  input  logic [2*SW-1:0]        cfg_thr_a,
  input  logic [2*SW-1:0]        cfg_thr_b,
  input  logic                   sync_evt,
  input  logic                   smp_valid,
  input  logic signed [SW-1:0]   smp_i,
  input  logic signed [SW-1:0]   smp_q,
  input  logic                   smp_gate,
  input  logic                   rd_req,
  input  logic                   rd_done,
  output logic [2*SW+CW-1:0]     res_power,
  output logic [2*SW-1:0]        res_peak,
  output logic [CW-1:0]          res_hist_a,
  output logic [CW-1:0]          res_hist_b,
  output logic                   res_irq,
  output logic                   rd_ack
);
  localparam int MW = 2 * SW;
  localparam int AW = MW + CW;

  logic                         win_on, win_start, win_end, win_use;
  logic [AW-1:0]                run_pwr, nx_pwr;
  logic [MW-1:0]                nx_peak;
  logic [PM_NHIST-1:0][CW-1:0]  nx_hist, res_hist;
  logic [PM_NHIST-1:0][MW-1:0]  thr;

  assign thr = {cfg_thr_b, cfg_thr_a};

  pm_sched #(.CW(CW)) u_sched (
    .clk(clk), .rst(rst), .mode(cfg_mode), .one_shot(cfg_one_shot),
    .dly(cfg_delay), .len(cfg_length), .ivl(cfg_interval),
    .sync(sync_evt), .vld(smp_valid), .gate(smp_gate),
    .win_on(win_on), .win_start(win_start), .win_end(win_end), .win_use(win_use)
  );

  pm_accum #(.SW(SW), .CW(CW)) u_acc (
    .clk(clk), .rst(rst), .smp_i(smp_i), .smp_q(smp_q), .thr(thr),
    .win_on(win_on), .win_start(win_start), .win_use(win_use),
    .acc_q(run_pwr), .nx_pwr(nx_pwr), .nx_peak(nx_peak), .nx_hist(nx_hist)
  );

  pm_handoff #(.SW(SW), .CW(CW)) u_hand (
    .clk(clk), .rst(rst), .hs_mode(cfg_handshake), .rd_req(rd_req),
    .rd_done(rd_done), .win_end(win_end), .nx_pwr(nx_pwr), .nx_peak(nx_peak),
    .nx_hist(nx_hist), .res_pwr(res_power), .res_peak(res_peak),
    .res_hist(res_hist), .irq(res_irq), .ack(rd_ack)
  );

  assign res_hist_a = res_hist[0];
  assign res_hist_b = res_hist[1];
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int SW = 16,
  parameter int CW = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          cfg_mode,
  input logic                cfg_handshake,
  input logic                rd_req,
  input logic                win_on,
  input logic                win_start,
  input logic                win_end,
  input logic [2*SW+CW-1:0]  run_pwr,
  input logic [2*SW+CW-1:0]  res_power,
  input logic [2*SW-1:0]     res_peak,
  input logic                res_irq,
  input logic                rd_ack
);
  // R3: the running sum only grows inside a window (a wrap would shrink it)
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (win_on && !win_start) |=> (run_pwr >= $past(run_pwr)));

  // R2: the latched peak is one of the summed terms
  p_peak_le_sum_r2: assert property (@(posedge clk) disable iff (rst)
    ({{CW{1'b0}}, res_peak} <= res_power));

  // R10: interrupt only follows a closed window
  p_irq_from_end_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(res_irq) |-> $past(win_end));

  // R11: acknowledge only rises under a request
  p_ack_needs_req_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_ack) |-> $past(rd_req));

  // R11: results frozen while acknowledged
  p_hold_while_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && cfg_handshake) |=> ($stable(res_power) && $stable(res_peak)));

  // R11: no interrupt in handshake mode
  p_no_irq_hs_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_handshake |=> !res_irq);

  // R7: no window once the meter is off
  p_off_no_window_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd0) |=> !win_on);
endmodule

bind iq_pwr_meter pm_checker #(.SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_handshake(cfg_handshake),
  .rd_req(rd_req), .win_on(win_on), .win_start(win_start), .win_end(win_end),
  .run_pwr(run_pwr), .res_power(res_power), .res_peak(res_peak),
  .res_irq(res_irq), .rd_ack(rd_ack)
);

// File: tb/iq_pwr_meter_bench.sv
module iq_pwr_meter_bench;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam int THR_A = 2000;
  localparam int THR_B = 8000;

  typedef struct {
    string  tag;
    longint pwr;
    longint peak;
    longint ha;
    longint hb;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic cfg_one_shot = 1'b0, cfg_handshake = 1'b0;
  logic [CW-1:0] cfg_delay = '0, cfg_length = '0, cfg_interval = '0;
  logic [2*SW-1:0] cfg_thr_a = 32'(THR_A), cfg_thr_b = 32'(THR_B);
  logic sync_evt = 1'b0, smp_valid = 1'b0, smp_gate = 1'b0;
  logic signed [SW-1:0] smp_i = '0, smp_q = '0;
  logic rd_req = 1'b0, done_auto = 1'b0, done_man = 1'b0;
  logic rd_done;
  logic [2*SW+CW-1:0] res_power;
  logic [2*SW-1:0] res_peak;
  logic [CW-1:0] res_hist_a, res_hist_b;
  logic res_irq, rd_ack;

  assign rd_done = done_auto | done_man;

  always #2.5 clk = ~clk;

  iq_pwr_meter #(.SW(SW), .CW(CW)) u_iq_pwr_meter (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_one_shot(cfg_one_shot),
    .cfg_handshake(cfg_handshake), .cfg_delay(cfg_delay), .cfg_length(cfg_length),
    .cfg_interval(cfg_interval), .cfg_thr_a(cfg_thr_a), .cfg_thr_b(cfg_thr_b),
    .sync_evt(sync_evt), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .smp_gate(smp_gate), .rd_req(rd_req), .rd_done(rd_done),
    .res_power(res_power), .res_peak(res_peak), .res_hist_a(res_hist_a),
    .res_hist_b(res_hist_b), .res_irq(res_irq), .rd_ack(rd_ack)
  );

  int n_chk = 0, n_bad = 0, n_evt = 0, idx = 0;
  bit sb_on = 1'b0, finished = 1'b0;
  logic irq_q = 1'b0, ack_q = 1'b0;
  exp_t sb[$];

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sample pattern by position after sync
  function automatic void gen(int seed, int kind, int k,
                              output int si, output int sq, output bit g);
    if (kind == 1) begin
      si = -32768; sq = -32768; g = 1'b1;
    end else begin
      si = ((k * 37 + seed * 11) % 201) - 100;
      sq = ((k * 53 + seed * 29 + 7) % 201) - 100;
      g  = (k % 3) != 0;
    end
  endfunction

  function automatic exp_t calc(string tag, int seed, int kind, int start, int len, bit gated);
    exp_t e;
    e.tag = tag; e.pwr = 0; e.peak = 0; e.ha = 0; e.hb = 0;
    for (int k = start; k < start + len; k++) begin
      int si, sq; bit g; longint m;
      gen(seed, kind, k, si, sq, g);
      if (!gated || g) begin
        m = longint'(si) * si + longint'(sq) * sq;
        e.pwr += m;
        if (m > e.peak) e.peak = m;
        if (m > THR_A) e.ha++;
        if (m > THR_B) e.hb++;
      end
    end
    return e;
  endfunction

  task automatic push(string tag, int seed, int kind, int start, int len, bit gated);
    sb.push_back(calc(tag, seed, kind, start, len, gated));
  endtask

  task automatic cmp(exp_t e);
    chk(e.tag, "power", longint'(res_power), e.pwr);
    chk(e.tag, "peak", longint'(res_peak), e.peak);
    chk(e.tag, "hist_a", longint'(res_hist_a), e.ha);
    chk(e.tag, "hist_b", longint'(res_hist_b), e.hb);
  endtask

  // monitor: pops the scoreboard on each new result
  always @(negedge clk) begin
    irq_q <= res_irq;
    ack_q <= rd_ack;
    done_auto <= 1'b0;
    if (!rst && ((res_irq && !irq_q) || (rd_ack && !ack_q))) begin
      n_evt++;
      if (sb_on) begin
        if (res_irq) done_auto <= 1'b1;
        if (sb.size() == 0) chk("R2", "unexpected result", 1, 0);
        else cmp(sb.pop_front());
      end
    end
  end

  task automatic cfg(int mode, bit os, bit hs, int dly, int len, int ivl);
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_one_shot = os; cfg_handshake = hs;
    cfg_delay = CW'(dly); cfg_length = CW'(len); cfg_interval = CW'(ivl);
  endtask

  task automatic do_sync();
    @(negedge clk);
    sync_evt = 1'b1; smp_valid = 1'b1; smp_i = 16'sd3000; smp_q = 16'sd3000; smp_gate = 1'b1;
    @(negedge clk);
    sync_evt = 1'b0; smp_valid = 1'b0;
    idx = 0;
  endtask

  task automatic stream(int n, int seed, int kind);
    for (int j = 0; j < n; j++) begin
      int si, sq; bit g;
      @(negedge clk);
      gen(seed, kind, idx, si, sq, g);
      smp_valid = 1'b1; smp_i = SW'(si); smp_q = SW'(sq); smp_gate = g;
      idx++;
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e0;
    exp_t e;
    longint r_pwr, r_peak;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13", "power", longint'(res_power), 0);
    chk("R13", "peak", longint'(res_peak), 0);
    chk("R13", "hist_a", longint'(res_hist_a), 0);
    chk("R13", "irq", longint'(res_irq), 0);
    chk("R13", "ack", longint'(rd_ack), 0);
    rst = 1'b0;
    sb_on = 1'b1;

    // R1 R2 R9 R12 R4: one-shot, restarted once mid-window
    cfg(1, 1, 0, 3, 5, 0);
    push("R1", 1, 0, 3, 5, 0);
    e0 = n_evt;
    do_sync(); stream(5, 1, 0);
    do_sync(); stream(20, 1, 0);
    idle(3);
    chk("R4", "windows after one-shot sync", n_evt - e0, 1);
    chk("R12", "pending expectations", sb.size(), 0);

    // R5 periodic
    cfg(1, 0, 0, 2, 4, 10);
    for (int m = 0; m < 3; m++) push("R5", 2, 0, m * 10 + 2, 4, 0);
    e0 = n_evt;
    do_sync(); stream(30, 2, 0);
    cfg(0, 0, 0, 2, 4, 10);
    idle(3);
    chk("R5", "periodic window count", n_evt - e0, 3);
    chk("R5", "pending expectations", sb.size(), 0);

    // R6 interval boundary
    cfg(1, 0, 0, 2, 4, 5);
    e0 = n_evt;
    do_sync(); stream(40, 3, 0);
    idle(3);
    chk("R6", "short interval results", n_evt - e0, 0);
    cfg(1, 0, 0, 2, 4, 6);
    push("R6", 3, 0, 2, 4, 0);
    push("R6", 3, 0, 8, 4, 0);
    e0 = n_evt;
    do_sync(); stream(12, 3, 0);
    cfg(0, 0, 0, 2, 4, 6);
    idle(3);
    chk("R6", "exact interval results", n_evt - e0, 2);

    // R8 gated
    cfg(2, 1, 0, 1, 6, 0);
    push("R8", 4, 0, 1, 6, 1);
    do_sync(); stream(15, 4, 0);
    idle(3);
    chk("R8", "pending expectations", sb.size(), 0);

    // R3 full scale
    cfg(1, 1, 0, 0, 8, 0);
    push("R3", 0, 1, 0, 8, 0);
    do_sync(); stream(10, 0, 1);
    idle(3);
    chk("R3", "pending expectations", sb.size(), 0);

    // R7 off
    r_pwr = longint'(res_power); r_peak = longint'(res_peak);
    cfg(0, 1, 0, 0, 3, 0);
    e0 = n_evt;
    do_sync(); stream(20, 5, 0);
    idle(3);
    chk("R7", "results while off", n_evt - e0, 0);
    chk("R7", "power unchanged", longint'(res_power), r_pwr);
    chk("R7", "peak unchanged", longint'(res_peak), r_peak);

    // R10 interrupt held, results overwritten
    sb_on = 1'b0;
    cfg(1, 0, 0, 0, 3, 5);
    e0 = n_evt;
    do_sync(); stream(12, 5, 0);
    cfg(0, 0, 0, 0, 3, 5);
    idle(5);
    e = calc("R10", 5, 0, 5, 3, 0);
    cmp(e);
    chk("R10", "irq held", longint'(res_irq), 1);
    chk("R10", "single irq rise", n_evt - e0, 1);
    done_man = 1'b1;
    @(negedge clk);
    done_man = 1'b0;
    chk("R10", "irq cleared by rd_done", longint'(res_irq), 0);

    // R11 handshake
    r_pwr = longint'(res_power);
    sb_on = 1'b1;
    cfg(1, 0, 1, 0, 4, 6);
    e0 = n_evt;
    do_sync(); stream(20, 6, 0);
    idle(2);
    chk("R11", "no load without request", longint'(res_power), r_pwr);
    chk("R11", "no ack without request", longint'(rd_ack), 0);
    chk("R11", "irq stays low", longint'(res_irq), 0);
    push("R11", 6, 0, 18, 4, 0);
    rd_req = 1'b1;
    stream(20, 6, 0);
    idle(2);
    e = calc("R11", 6, 0, 18, 4, 0);
    chk("R11", "ack held", longint'(rd_ack), 1);
    chk("R11", "results frozen", longint'(res_power), e.pwr);
    chk("R11", "one capture", n_evt - e0, 1);
    rd_req = 1'b0;
    @(negedge clk);
    chk("R11", "ack clears after request drop", longint'(rd_ack), 0);
    cfg(0, 0, 0, 0, 4, 6);
    idle(2);
    chk("R11", "pending expectations", sb.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule